// File: doc/BRIEF.md
# PWM Output Conditioning Stage

This block sits between a bank of PWM generators and the output pins. It receives `NUM_CH` raw PWM waveforms, one fault flag per generator, and software configuration. Each channel passes through three stages in a fixed order. First an enable gate is applied. Then an optional fault override is applied. Last, an optional inversion is applied. The result is registered, so the pins carry no combinational glitches. Two neighbouring channels share one generator: channels 2k and 2k+1 follow the fault flag and the local sync pulse of generator k.

Software writes the whole enable mask with one strobe. Each channel has its own update mode, which controls when the written bit reaches that channel's active enable:
- immediately,
- at the next local sync pulse of the channel's generator, or
- at the next global sync pulse.

A group of outputs, such as one commutation step of a motor bridge, can therefore be switched with one write and committed together at a safe point in the PWM period.

Top module: `pwm_out_cond`

## Requirements
- R1: While `rst` is high, `pin_out` is all zeros. After reset every active enable bit is 0 and no enable write is pending.
- R2: A channel whose active enable is 0, and which is not fault-forced, drives 0 before inversion. Its pin therefore equals its `invert` bit.
- R3: A channel that is enabled and not fault-forced drives `pwm_raw ^ invert` on its pin. The pin changes one clock after the inputs change.
- R4: A channel is fault-forced when `gen_fault[i/2]` and `fault_act[i]` are both 1. A fault-forced channel drives `fault_val[i] ^ invert[i]` one clock later, whatever its enable and raw input are.
- R5: When `fault_act[i]` is 0, channel i ignores the fault flag of its generator and keeps passing its gated raw signal.
- R6: A fault flag affects only the two channels of its own generator.
- R7: Update mode codes 0 and 3 are immediate. With either code, an `en_wr` at edge n sets the channel's active enable to `en_wdata[i]` at edge n, and the pin reflects it at edge n+1.
- R8: With update mode code 1 (local), a written bit is held pending. It moves to the active enable on a `local_sync[i/2]` pulse. Local pulses of other generators and `global_sync` leave it pending.
- R9: With update mode code 2 (global), a written bit is held pending. It moves to the active enable on a `global_sync` pulse. `local_sync` pulses leave it pending.
- R10: A newer write replaces any pending value. A write in the same cycle as the channel's sync event is committed by that event.
- R11: Inversion is applied after the fault override. With `fault_act`, `fault_val` and `invert` all set, a fault-forced channel drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_raw | input | NUM_CH | Raw PWM waveforms from the generators |
| gen_fault | input | NUM_GEN | Fault flag per generator |
| local_sync | input | NUM_GEN | Local sync pulse per generator |
| global_sync | input | 1 | Global synchronised update pulse |
| en_wr | input | 1 | Enable-mask write strobe |
| en_wdata | input | NUM_CH | Enable mask value being written |
| upd_mode | input | 2*NUM_CH | Per-channel update mode: 0 or 3 immediate, 1 local, 2 global |
| fault_act | input | NUM_CH | Per-channel: force the fault value during a fault |
| fault_val | input | NUM_CH | Per-channel level forced during a fault |
| invert | input | NUM_CH | Per-channel output inversion |
| pin_out | output | NUM_CH | Registered conditioned outputs |

## Verification
A change in `pwm_raw`, `gen_fault`, fault configuration or `invert` reaches `pin_out` one rising edge after it is driven. An enable write, or a sync pulse that commits a pending bit, takes two edges: the first updates the active enable and the second updates the output register. Every stimulus is driven on a falling edge. Each check then waits for exactly the number of rising edges due for that result, and samples on the next falling edge. The immediate-write test also samples after the first edge, to confirm the pin has not moved yet. The sync tests check that the pins are unchanged while a write is pending and that unrelated sync pulses have no effect.

// File: rtl/pwm_cond_pkg.sv
package pwm_cond_pkg;

    typedef enum logic [1:0] {
        UPD_NOW     = 2'd0,
        UPD_LOCAL   = 2'd1,
        UPD_GLOBAL  = 2'd2,
        UPD_NOW_ALT = 2'd3
    } upd_mode_e;

    typedef struct packed {
        logic raw;
        logic en;
        logic fault;
        logic f_act;
        logic f_val;
        logic inv;
    } chan_cond_t;

    function automatic logic is_immediate(upd_mode_e m);
        return (m == UPD_NOW) || (m == UPD_NOW_ALT);
    endfunction

    // gate -> fault override -> inversion
    function automatic logic cond_level(chan_cond_t c);
        logic v;
        v = c.raw & c.en;
        if (c.fault && c.f_act)
            v = c.f_val;
        return v ^ c.inv;
    endfunction

endpackage

// File: rtl/pwm_en_chan.sv
module pwm_en_chan
    import pwm_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       wdata,
    input  logic [1:0] mode,
    input  logic       local_sync,
    input  logic       global_sync,
    output logic       act_en
);

    logic      shadow;
    logic      pend;
    upd_mode_e mode_e;
    logic      imm;
    logic      sync_hit;
    logic      cand;
    logic      have;

    always_comb begin
        mode_e   = upd_mode_e'(mode);
        imm      = is_immediate(mode_e);
        sync_hit = ((mode_e == UPD_LOCAL)  && local_sync) ||
                   ((mode_e == UPD_GLOBAL) && global_sync);
        cand     = wr ? wdata : shadow;
        have     = wr || pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_en <= 1'b0;
            shadow <= 1'b0;
            pend   <= 1'b0;
        end else if (wr && imm) begin
            act_en <= wdata;
            shadow <= wdata;
            pend   <= 1'b0;
        end else if (have && sync_hit) begin
            act_en <= cand;
            shadow <= cand;
            pend   <= 1'b0;
        end else if (wr) begin
            shadow <= wdata;
            pend   <= 1'b1;
        end
    end

endmodule

// File: rtl/pwm_fault_gate.sv
module pwm_fault_gate
    import pwm_cond_pkg::*;
(
    input  chan_cond_t cond,
    output logic       level
);

    always_comb level = cond_level(cond);

endmodule

// File: rtl/pwm_pin_reg.sv
module pwm_pin_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/pwm_out_cond.sv
module pwm_out_cond
    import pwm_cond_pkg::*;
#(
    parameter  int NUM_CH  = 8,
    localparam int NUM_GEN = (NUM_CH + 1) / 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     pwm_raw,
    input  logic [NUM_GEN-1:0]    gen_fault,
    input  logic [NUM_GEN-1:0]    local_sync,
    input  logic                  global_sync,
    input  logic                  en_wr,
    input  logic [NUM_CH-1:0]     en_wdata,
    input  logic [2*NUM_CH-1:0]   upd_mode,
    input  logic [NUM_CH-1:0]     fault_act,
    input  logic [NUM_CH-1:0]     fault_val,
    input  logic [NUM_CH-1:0]     invert,
    output logic [NUM_CH-1:0]     pin_out
);

    logic [NUM_CH-1:0] act_en;
    logic [NUM_CH-1:0] next_pin;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int GEN = i / 2;
        chan_cond_t cond;

        pwm_en_chan u_en (
            .clk         (clk),
            .rst         (rst),
            .wr          (en_wr),
            .wdata       (en_wdata[i]),
            .mode        (upd_mode[2*i +: 2]),
            .local_sync  (local_sync[GEN]),
            .global_sync (global_sync),
            .act_en      (act_en[i])
        );

        always_comb begin
            cond.raw   = pwm_raw[i];
            cond.en    = act_en[i];
            cond.fault = gen_fault[GEN];
            cond.f_act = fault_act[i];
            cond.f_val = fault_val[i];
            cond.inv   = invert[i];
        end

        pwm_fault_gate u_gate (
            .cond  (cond),
            .level (next_pin[i])
        );
    end

    pwm_pin_reg #(.WIDTH(NUM_CH)) u_pins (
        .clk (clk),
        .rst (rst),
        .d   (next_pin),
        .q   (pin_out)
    );

endmodule

// File: rtl/pwm_out_cond_chk.sv
module pwm_out_cond_chk #(
    parameter int NUM_CH  = 8,
    parameter int NUM_GEN = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_CH-1:0]   pwm_raw,
    input logic [NUM_GEN-1:0]  gen_fault,
    input logic [NUM_GEN-1:0]  local_sync,
    input logic                global_sync,
    input logic                en_wr,
    input logic [NUM_CH-1:0]   en_wdata,
    input logic [2*NUM_CH-1:0] upd_mode,
    input logic [NUM_CH-1:0]   fault_act,
    input logic [NUM_CH-1:0]   fault_val,
    input logic [NUM_CH-1:0]   invert,
    input logic [NUM_CH-1:0]   act_en,
    input logic [NUM_CH-1:0]   pin_out
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        localparam int G = i / 2;

        // R4 R11
        fault_force_chk: assert property (@(posedge clk) disable iff (rst)
            (gen_fault[G] && fault_act[i]) |=>
                (pin_out[i] == ($past(fault_val[i]) ^ $past(invert[i]))));

        // R2
        disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (!act_en[i] && !(gen_fault[G] && fault_act[i])) |=>
                (pin_out[i] == $past(invert[i])));

        // R3 R5
        pass_through_chk: assert property (@(posedge clk) disable iff (rst)
            (act_en[i] && !(gen_fault[G] && fault_act[i])) |=>
                (pin_out[i] == ($past(pwm_raw[i]) ^ $past(invert[i]))));

        // R7
        imm_write_chk: assert property (@(posedge clk) disable iff (rst)
            (en_wr && (upd_mode[2*i +: 2] == 2'd0 || upd_mode[2*i +: 2] == 2'd3)) |=>
                (act_en[i] == $past(en_wdata[i])));

        // R8
        local_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (upd_mode[2*i +: 2] == 2'd1 && !en_wr && !local_sync[G]) |=>
                $stable(act_en[i]));

        // R9
        global_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (upd_mode[2*i +: 2] == 2'd2 && !en_wr && !global_sync) |=>
                $stable(act_en[i]));
    end

endmodule

bind pwm_out_cond pwm_out_cond_chk #(.NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN)) u_chk (.*);

// File: tb/tb_pwm_out_cond.sv
module tb_pwm_out_cond;

    localparam int NC = 8;
    localparam int NG = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NC-1:0] pwm_raw;
    logic [NG-1:0] gen_fault;
    logic [NG-1:0] local_sync;
    logic          global_sync;
    logic          en_wr;
    logic [NC-1:0] en_wdata;
    logic [2*NC-1:0] upd_mode;
    logic [NC-1:0] fault_act;
    logic [NC-1:0] fault_val;
    logic [NC-1:0] invert;
    logic [NC-1:0] pin_out;

    int nvec = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    pwm_out_cond #(.NUM_CH(NC)) dut (
        .clk(clk), .rst(rst), .pwm_raw(pwm_raw), .gen_fault(gen_fault),
        .local_sync(local_sync), .global_sync(global_sync), .en_wr(en_wr),
        .en_wdata(en_wdata), .upd_mode(upd_mode), .fault_act(fault_act),
        .fault_val(fault_val), .invert(invert), .pin_out(pin_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [NC-1:0] act, logic [NC-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: pin_out=%h expected=%h", req, act, exp);
        end
    endtask

    // immediate write of a mask, leaves mode immediate
    task automatic set_mask_now(logic [NC-1:0] m);
        upd_mode = '0;
        en_wdata = m;
        en_wr    = 1'b1;
        tick();
        en_wr    = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1; pwm_raw = '1; gen_fault = '0; local_sync = '0;
        global_sync = 1'b0; en_wr = 1'b0; en_wdata = '0; upd_mode = '0;
        fault_act = '0; fault_val = '0; invert = 8'hFF;
        tick(); tick();
        check("R1 reset", pin_out, 8'h00);
        rst = 1'b0;
        invert = '0;
        tick();
        check("R1 enables clear after reset", pin_out, 8'h00);
    endtask

    task automatic t_disabled();
        invert = 8'hA5; pwm_raw = '1;
        tick();
        check("R2 disabled shows invert", pin_out, 8'hA5);
        invert = '0;
        tick();
    endtask

    task automatic t_immediate();
        pwm_raw  = 8'h3C;
        upd_mode = '0;
        en_wdata = 8'hFF;
        en_wr    = 1'b1;
        tick();
        en_wr = 1'b0;
        check("R7 pin not yet updated", pin_out, 8'h00);
        tick();
        check("R7 R3 enabled passes raw", pin_out, 8'h3C);
        invert = 8'h0F;
        tick();
        check("R3 raw xor invert", pin_out, 8'h33);
        invert = '0;
        upd_mode = 16'hFFFF;   // code 3 everywhere
        en_wdata = 8'h0F; pwm_raw = 8'hFF;
        en_wr = 1'b1;
        tick();
        en_wr = 1'b0;
        tick();
        check("R7 code 3 immediate", pin_out, 8'h0F);
    endtask

    task automatic t_fault();
        set_mask_now(8'hFF);
        pwm_raw = 8'h00; fault_act = 8'hFF; fault_val = 8'h0C; gen_fault = 4'b0010;
        tick();
        check("R4 R6 fault on generator 1 only", pin_out, 8'h0C);
        pwm_raw = 8'hFF; fault_val = 8'h00;
        tick();
        check("R4 R6 forced low, others pass", pin_out, 8'hF3);
        fault_act = 8'h00;
        tick();
        check("R5 fault ignored without fault_act", pin_out, 8'hFF);
        fault_act = 8'hFF; fault_val = 8'hFF; invert = 8'hFF; gen_fault = 4'hF;
        tick();
        check("R11 invert after override", pin_out, 8'h00);
        invert = '0;
        set_mask_now(8'h00);
        check("R4 overrides disabled channel", pin_out, 8'hFF);
        gen_fault = '0; fault_act = '0; fault_val = '0;
        tick();
        check("R2 disabled after fault clears", pin_out, 8'h00);
    endtask

    task automatic t_local();
        set_mask_now(8'h00);
        pwm_raw  = 8'hFF;
        upd_mode = 16'h5555;
        en_wdata = 8'hFF; en_wr = 1'b1;
        tick();
        en_wr = 1'b0;
        tick();
        check("R8 pending until local sync", pin_out, 8'h00);
        global_sync = 1'b1;
        tick();
        global_sync = 1'b0;
        tick();
        check("R8 global sync ignored", pin_out, 8'h00);
        local_sync = 4'b0100;
        tick();
        local_sync = '0;
        tick();
        check("R8 generator 2 commits", pin_out, 8'h30);
        local_sync = 4'b1011;
        tick();
        local_sync = '0;
        tick();
        check("R8 remaining commit", pin_out, 8'hFF);
    endtask

    task automatic t_global();
        set_mask_now(8'h00);
        pwm_raw  = 8'hFF;
        upd_mode = 16'hAAAA;
        en_wdata = 8'h0F; en_wr = 1'b1;
        tick();
        en_wr = 1'b0;
        local_sync = 4'hF;
        tick();
        local_sync = '0;
        tick();
        check("R9 local sync ignored", pin_out, 8'h00);
        global_sync = 1'b1;
        tick();
        global_sync = 1'b0;
        tick();
        check("R9 global commit", pin_out, 8'h0F);
    endtask

    task automatic t_replace();
        upd_mode = 16'hAAAA;
        en_wdata = 8'hF0; en_wr = 1'b1;
        tick();
        en_wdata = 8'h3C;
        tick();
        en_wr = 1'b0;
        tick();
        check("R10 still old before sync", pin_out, 8'h0F);
        global_sync = 1'b1;
        tick();
        global_sync = 1'b0;
        tick();
        check("R10 newer write replaces pending", pin_out, 8'h3C);
        en_wdata = 8'hC3; en_wr = 1'b1; global_sync = 1'b1;
        tick();
        en_wr = 1'b0; global_sync = 1'b0;
        tick();
        check("R10 write with sync commits", pin_out, 8'hC3);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_immediate();
        t_fault();
        t_local();
        t_global();
        t_replace();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nvec++;
        nerr++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule